// File: doc/BRIEF.md
# Single-Cycle Stack Machine Core

This block is a 16-bit processor with no accumulator and no general registers. Every computation goes through an operand stack. The topmost entry is held in a register, and the deeper entries sit in a small array. Code and data share one 4096-word memory inside the core. That memory is modelled as a synchronous RAM with two ports. One port fetches the next instruction while the other serves the data read or write of the current one, so every instruction retires in exactly one clock.

Each instruction is one 16-bit word. The upper four bits select the operation. The lower twelve bits carry an immediate, a memory address, or an arithmetic function code. The core reads one 16-bit input port and drives one 16-bit output register. A halt instruction freezes the machine, and the `halted` flag stays high until the next reset. A testbench or an enclosing system fills the RAM before reset is released. Execution then starts at address 0.

Top module: `stack_core`

## Requirements
- R1: Opcode field is bits [15:12], argument field is bits [11:0]. Opcodes: 0 halt, 1 push immediate, 2 push from memory, 3 pop to memory, 4 jump, 5 jump if top is zero, 6 jump if top is nonzero, 7 load indirect, 8 store indirect, D read input, E write output, F arithmetic with function code in bits [4:0].
- R2: A synchronous active-high reset sets the program counter to 0, empties the stack, clears `out_data` and deasserts `halted`; the first instruction executed after reset is the one at address 0.
- R3: Every instruction takes one clock: a straight program whose halt sits at index h asserts `halted` on the (h+1)-th rising edge after reset is released, and a non-jumping instruction advances the program counter by one.
- R4: Push immediate places the 12-bit argument, zero-extended, on the stack; read input pushes `in_data`; write output copies top to `out_data` and pops it; each push adds exactly one entry.
- R5: Push from memory pushes mem[A]; pop to memory writes top to mem[A] and removes it, exposing the entry below.
- R6: Load indirect replaces top with mem[top[11:0]]; store indirect writes top to mem[next[11:0]] and removes both entries.
- R7: Jump loads A into the program counter; jump-if-zero and jump-if-nonzero load A only when their condition on top holds, and pop top whether or not the branch is taken.
- R8: Binary functions take next as left operand and top as right operand and replace both with the 16-bit result: 0 add, 1 subtract, 2 multiply (low 16 bits), 3 shift left, 4 logical shift right, 5 bitwise and, 6 bitwise or, 7 bitwise xor.
- R9: Functions 8 logical and, 9 logical or, A equal, B not equal, C greater-or-equal, D less-or-equal, E greater, F less yield 1 or 0; the ordering tests treat operands as signed two's complement.
- R10: Unary functions act on top alone: 10 two's-complement negate, 11 bitwise invert, 12 logical not (1 if top is zero, else 0).
- R11: After a halt executes, the program counter holds, `halted` stays high until reset, and neither later memory words nor `in_data` change `out_data`.
- R12: `out_data` changes only when a write-output instruction executes, whatever the stack does meanwhile.
- R13: A value that push from memory or load indirect has just produced can be used by the next instruction, including a further load indirect, without any stall cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 16 | Value pushed by the read-input instruction |
| out_data | output | 16 | Output register written by the write-output instruction |
| halted | output | 1 | High from the cycle after a halt until reset |

## Verification
On every cycle the bound checker verifies several properties. It confirms the program counter moves by exactly one, or to the jump argument, after each executed instruction. It also checks that the stack depth follows pushes and double pops, that `out_data` stays put unless a write-output runs, and that a halted core keeps its program counter and flag. The checker also covers the state the core enters on reset. Some results appear only in the bench's programs and are read at the output port: the ALU operand order and signed comparisons, zero extension, memory round trips through pop, store and load, the chained reads that rely on the forwarded memory value, and the exact cycle count of straight and looping code.

// File: rtl/stack_core_pkg.sv
package stack_core_pkg;
  localparam int WORD_W = 16;
  localparam int OPC_W  = 4;
  localparam int ARG_W  = WORD_W - OPC_W;
  localparam int FN_W   = 5;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [OPC_W-1:0] {
    OPC_HALT  = 4'h0,
    OPC_PUSHI = 4'h1,
    OPC_PUSHM = 4'h2,
    OPC_POPM  = 4'h3,
    OPC_JMP   = 4'h4,
    OPC_JZ    = 4'h5,
    OPC_JNZ   = 4'h6,
    OPC_LDI   = 4'h7,
    OPC_STI   = 4'h8,
    OPC_IN    = 4'hD,
    OPC_OUT   = 4'hE,
    OPC_ALU   = 4'hF
  } opc_e;

  typedef enum logic [2:0] {
    STK_HOLD,
    STK_PUSH,
    STK_POP1,
    STK_POP2,
    STK_REPL
  } stk_op_e;

  function automatic word_t as_flag(input logic b);
    return {{(WORD_W-1){1'b0}}, b};
  endfunction

  // Flipping the sign bit maps signed order onto unsigned order.
  function automatic word_t sign_bias(input word_t v);
    return {~v[WORD_W-1], v[WORD_W-2:0]};
  endfunction

  function automatic logic fn_unary(input logic [FN_W-1:0] f);
    return f[FN_W-1];
  endfunction

  function automatic word_t alu_eval(input logic [FN_W-1:0] f, input word_t l, input word_t r);
    word_t lb, rb;
    lb = sign_bias(l);
    rb = sign_bias(r);
    case (f)
      5'h00: return l + r;
      5'h01: return l - r;
      5'h02: return l * r;
      5'h03: return l << r;
      5'h04: return l >> r;
      5'h05: return l & r;
      5'h06: return l | r;
      5'h07: return l ^ r;
      5'h08: return as_flag((l != '0) && (r != '0));
      5'h09: return as_flag((l != '0) || (r != '0));
      5'h0A: return as_flag(l == r);
      5'h0B: return as_flag(l != r);
      5'h0C: return as_flag(lb >= rb);
      5'h0D: return as_flag(lb <= rb);
      5'h0E: return as_flag(lb > rb);
      5'h0F: return as_flag(lb < rb);
      5'h10: return '0 - r;
      5'h11: return ~r;
      5'h12: return as_flag(r == '0);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/stack_alu.sv
module stack_alu
  import stack_core_pkg::*;
(
  input  logic [FN_W-1:0]   fn,
  input  logic [WORD_W-1:0] lhs,
  input  logic [WORD_W-1:0] rhs,
  output logic [WORD_W-1:0] res,
  output logic              unary
);
  always_comb begin
    res   = alu_eval(fn, lhs, rhs);
    unary = fn_unary(fn);
  end
endmodule

// File: rtl/stack_ram.sv
module stack_ram
  import stack_core_pkg::*;
#(
  parameter int AW = ARG_W
) (
  input  logic              clk,
  input  logic [AW-1:0]     f_addr,
  output logic [WORD_W-1:0] f_data,
  input  logic              d_we,
  input  logic              d_re,
  input  logic [AW-1:0]     d_addr,
  input  logic [WORD_W-1:0] d_wdata,
  output logic [WORD_W-1:0] d_rdata
);
  localparam int WORDS = 1 << AW;

  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    f_data <= mem[f_addr];
    if (d_we)
      mem[d_addr] <= d_wdata;
    else if (d_re)
      d_rdata <= mem[d_addr];
  end
endmodule

// File: rtl/stack_lifo.sv
module stack_lifo
  import stack_core_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  stk_op_e           op,
  input  logic [WORD_W-1:0] spill,
  input  logic [WORD_W-1:0] top_new,
  output logic [WORD_W-1:0] top_q,
  output logic [WORD_W-1:0] next_q,
  output logic [WORD_W-1:0] third_q,
  output logic [CNT_W-1:0]  count
);
  logic [WORD_W-1:0] below [DEPTH];
  logic [PTR_W-1:0]  sp;

  assign next_q  = below[sp - PTR_W'(1)];
  assign third_q = below[sp - PTR_W'(2)];

  always_ff @(posedge clk) begin
    if (op == STK_PUSH)
      below[sp] <= spill;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp    <= '0;
      count <= '0;
      top_q <= '0;
    end else begin
      case (op)
        STK_PUSH: begin
          sp    <= sp + PTR_W'(1);
          count <= count + CNT_W'(1);
          top_q <= top_new;
        end
        STK_POP1: begin
          sp    <= sp - PTR_W'(1);
          count <= count - CNT_W'(1);
          top_q <= top_new;
        end
        STK_POP2: begin
          sp    <= sp - PTR_W'(2);
          count <= count - CNT_W'(2);
          top_q <= top_new;
        end
        STK_REPL: top_q <= top_new;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stack_core.sv
module stack_core
  import stack_core_pkg::*;
#(
  parameter int STACK_DEPTH = 16,
  localparam int AW    = ARG_W,
  localparam int CNT_W = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_data,
  output logic [WORD_W-1:0] out_data,
  output logic              halted
);
  logic [AW-1:0]     pc_q, fetch_addr, arg;
  logic [WORD_W-1:0] ir, ram_q, top_q, next_q, third_q, top_eff, top_new;
  logic [WORD_W-1:0] alu_res, d_wdata;
  logic [FN_W-1:0]   fn;
  logic [CNT_W-1:0]  depth;
  logic [AW-1:0]     d_addr;
  logic              alu_unary, pend_q, from_ram, d_we, d_re;
  opc_e              opc;
  stk_op_e           stk_op;

  // Named events for the bound checker
  logic ev_exec, ev_jump, ev_halt, ev_out, ev_push, ev_pop2;

  assign opc     = opc_e'(ir[WORD_W-1 -: OPC_W]);
  assign arg     = ir[AW-1:0];
  assign fn      = ir[FN_W-1:0];
  assign ev_exec = !rst && !halted;
  // Top is forwarded from the RAM data port for one instruction after a memory read
  assign top_eff = pend_q ? ram_q : top_q;
  assign ev_push = (stk_op == STK_PUSH);
  assign ev_pop2 = (stk_op == STK_POP2);

  stack_alu u_alu (
    .fn   (fn),
    .lhs  (next_q),
    .rhs  (top_eff),
    .res  (alu_res),
    .unary(alu_unary)
  );

  always_comb begin
    stk_op   = STK_HOLD;
    top_new  = top_eff;
    from_ram = 1'b0;
    d_we     = 1'b0;
    d_re     = 1'b0;
    d_addr   = arg;
    d_wdata  = top_eff;
    ev_jump  = 1'b0;
    ev_halt  = 1'b0;
    ev_out   = 1'b0;
    if (ev_exec) begin
      case (opc)
        OPC_HALT:  ev_halt = 1'b1;
        OPC_PUSHI: begin
          stk_op  = STK_PUSH;
          top_new = WORD_W'(arg);
        end
        OPC_PUSHM: begin
          stk_op   = STK_PUSH;
          d_re     = 1'b1;
          from_ram = 1'b1;
        end
        OPC_POPM: begin
          stk_op  = STK_POP1;
          top_new = next_q;
          d_we    = 1'b1;
        end
        OPC_JMP:   ev_jump = 1'b1;
        OPC_JZ: begin
          ev_jump = (top_eff == '0);
          stk_op  = STK_POP1;
          top_new = next_q;
        end
        OPC_JNZ: begin
          ev_jump = (top_eff != '0);
          stk_op  = STK_POP1;
          top_new = next_q;
        end
        OPC_LDI: begin
          stk_op   = STK_REPL;
          d_re     = 1'b1;
          d_addr   = top_eff[AW-1:0];
          from_ram = 1'b1;
        end
        OPC_STI: begin
          stk_op  = STK_POP2;
          top_new = third_q;
          d_we    = 1'b1;
          d_addr  = next_q[AW-1:0];
        end
        OPC_IN: begin
          stk_op  = STK_PUSH;
          top_new = in_data;
        end
        OPC_OUT: begin
          stk_op  = STK_POP1;
          top_new = next_q;
          ev_out  = 1'b1;
        end
        OPC_ALU: begin
          stk_op  = alu_unary ? STK_REPL : STK_POP1;
          top_new = alu_res;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (rst)
      fetch_addr = '0;
    else if (!ev_exec || ev_halt)
      fetch_addr = pc_q;
    else if (ev_jump)
      fetch_addr = arg;
    else
      fetch_addr = pc_q + AW'(1);
  end

  stack_ram #(.AW(AW)) u_ram (
    .clk    (clk),
    .f_addr (fetch_addr),
    .f_data (ir),
    .d_we   (d_we),
    .d_re   (d_re),
    .d_addr (d_addr),
    .d_wdata(d_wdata),
    .d_rdata(ram_q)
  );

  stack_lifo #(.DEPTH(STACK_DEPTH)) u_stk (
    .clk    (clk),
    .rst    (rst),
    .op     (stk_op),
    .spill  (top_eff),
    .top_new(top_new),
    .top_q  (top_q),
    .next_q (next_q),
    .third_q(third_q),
    .count  (depth)
  );

  always_ff @(posedge clk) begin
    pc_q <= fetch_addr;
    if (rst) begin
      halted   <= 1'b0;
      out_data <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (ev_halt) halted <= 1'b1;
      if (ev_out) out_data <= top_eff;
      if (stk_op != STK_HOLD) pend_q <= from_ram;
    end
  end
endmodule

// File: rtl/stack_core_chk.sv
module stack_core_chk
  import stack_core_pkg::*;
#(
  parameter int AW    = ARG_W,
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              halted,
  input logic [WORD_W-1:0] out_data,
  input logic [AW-1:0]     pc,
  input logic [AW-1:0]     jump_target,
  input logic [CNT_W-1:0]  depth,
  input logic              ev_exec,
  input logic              ev_jump,
  input logic              ev_halt,
  input logic              ev_out,
  input logic              ev_push,
  input logic              ev_pop2
);
  assert_reset_state_R2: assert property (@(posedge clk)
    rst |=> (pc == '0 && out_data == '0 && !halted && depth == '0));

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
    (ev_exec && !ev_jump && !ev_halt) |=> (pc == $past(pc) + 1'b1));

  assert_push_depth_R4: assert property (@(posedge clk) disable iff (rst)
    ev_push |=> (depth == $past(depth) + 1'b1));

  assert_store_pops_two_R6: assert property (@(posedge clk) disable iff (rst)
    ev_pop2 |=> (depth == $past(depth) - 2'd2));

  assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
    ev_jump |=> (pc == $past(jump_target)));

  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc)));

  assert_out_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !ev_out |=> $stable(out_data));
endmodule

bind stack_core stack_core_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .halted     (halted),
  .out_data   (out_data),
  .pc         (pc_q),
  .jump_target(arg),
  .depth      (depth),
  .ev_exec    (ev_exec),
  .ev_jump    (ev_jump),
  .ev_halt    (ev_halt),
  .ev_out     (ev_out),
  .ev_push    (ev_push),
  .ev_pop2    (ev_pop2)
);

// File: tb/tb_stack_core.sv
module tb_stack_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] in_data = '0;
  logic [15:0] out_data;
  logic        halted;
  int checks = 0;
  int failures = 0;

  // Opcodes per R1
  localparam logic [3:0] K_HALT = 4'h0, K_PSI = 4'h1, K_PSM = 4'h2, K_POP = 4'h3,
                         K_JMP = 4'h4, K_JZ = 4'h5, K_JNZ = 4'h6, K_LD = 4'h7,
                         K_ST = 4'h8, K_IN = 4'hD, K_OUT = 4'hE, K_OP = 4'hF;

  stack_core dut (.clk(clk), .rst(rst), .in_data(in_data), .out_data(out_data), .halted(halted));

  always #5 clk = ~clk;

  function automatic logic [15:0] ins(input logic [3:0] o, input int a);
    return {o, a[11:0]};
  endfunction

  function automatic logic [15:0] model_op(input int f, input logic [15:0] l, input logic [15:0] r);
    int sl, sr;
    sl = int'($signed(l));
    sr = int'($signed(r));
    case (f)
      0: return 16'(l + r);
      1: return 16'(l - r);
      2: return 16'(32'(l) * 32'(r));
      3: return (r > 15) ? 16'h0 : 16'(l << r);
      4: return (r > 15) ? 16'h0 : 16'(l >> r);
      5: return l & r;
      6: return l | r;
      7: return l ^ r;
      8: return (l != 0 && r != 0) ? 16'd1 : 16'd0;
      9: return (l != 0 || r != 0) ? 16'd1 : 16'd0;
      10: return (l == r) ? 16'd1 : 16'd0;
      11: return (l != r) ? 16'd1 : 16'd0;
      12: return (sl >= sr) ? 16'd1 : 16'd0;
      13: return (sl <= sr) ? 16'd1 : 16'd0;
      14: return (sl > sr) ? 16'd1 : 16'd0;
      15: return (sl < sr) ? 16'd1 : 16'd0;
      16: return 16'(-sr);
      17: return ~r;
      18: return (r == 0) ? 16'd1 : 16'd0;
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic begin_prog;
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 4096; i++) dut.u_ram.mem[i] <= 16'h0;
  endtask

  task automatic put(input int a, input logic [15:0] v);
    dut.u_ram.mem[a] <= v;
  endtask

  task automatic run_prog(output int ncyc);
    @(posedge clk);
    @(negedge clk);
    check("R2 reset out_data", out_data, 16'h0);
    check("R2 reset halted", {15'h0, halted}, 16'h0);
    rst = 1'b0;
    ncyc = 0;
    while (!halted && ncyc < 2000) begin
      @(posedge clk);
      @(negedge clk);
      ncyc++;
    end
  endtask

  task automatic t_pushi_zero_ext;
    int n;
    begin_prog;
    put(0, ins(K_PSI, 12'hFFF)); put(1, ins(K_OUT, 0)); put(2, ins(K_HALT, 0));
    run_prog(n);
    check("R4 pushi zero-extend", out_data, 16'h0FFF);
    check("R3 straight cycles", 16'(n), 16'd3);
  endtask

  task automatic t_bin(input int f, input int a, input bit na, input int b, input bit nb, input string req);
    int n, k;
    logic [15:0] l, r;
    begin_prog;
    k = 0;
    put(k++, ins(K_PSI, a));
    if (na) put(k++, ins(K_OP, 16));
    put(k++, ins(K_PSI, b));
    if (nb) put(k++, ins(K_OP, 16));
    put(k++, ins(K_OP, f)); put(k++, ins(K_OUT, 0)); put(k++, ins(K_HALT, 0));
    run_prog(n);
    l = na ? 16'(-a) : 16'(a);
    r = nb ? 16'(-b) : 16'(b);
    check(req, out_data, model_op(f, l, r));
    check("R3 cycles with alu", 16'(n), 16'(k));
  endtask

  task automatic t_unary(input int f, input int a);
    int n;
    begin_prog;
    put(0, ins(K_PSI, a)); put(1, ins(K_OP, f)); put(2, ins(K_OUT, 0)); put(3, ins(K_HALT, 0));
    run_prog(n);
    check("R10 unary", out_data, model_op(f, 16'h0, 16'(a)));
  endtask

  task automatic t_push_pop;
    int n;
    begin_prog;
    put(0, ins(K_PSI, 9)); put(1, ins(K_PSI, 12'h123)); put(2, ins(K_POP, 12'h180));
    put(3, ins(K_PSM, 12'h180)); put(4, ins(K_OP, 1)); put(5, ins(K_OUT, 0)); put(6, ins(K_HALT, 0));
    run_prog(n);
    check("R5 pop/push round trip", out_data, 16'(9 - 12'h123));
    begin_prog;
    put(12'h150, 16'h8001);
    put(0, ins(K_PSM, 12'h150)); put(1, ins(K_PSI, 1)); put(2, ins(K_OP, 0));
    put(3, ins(K_OUT, 0)); put(4, ins(K_HALT, 0));
    run_prog(n);
    check("R5 push preloaded word", out_data, 16'h8002);
  endtask

  task automatic t_load_store;
    int n;
    begin_prog;
    put(12'h210, 16'h0ABC); put(12'hABC, 16'h1234);
    put(0, ins(K_PSI, 12'h210)); put(1, ins(K_LD, 0)); put(2, ins(K_LD, 0));
    put(3, ins(K_OUT, 0)); put(4, ins(K_HALT, 0));
    run_prog(n);
    check("R13 chained loads", out_data, 16'h1234);
    check("R6 load cycles", 16'(n), 16'd5);
    begin_prog;
    put(0, ins(K_PSI, 7)); put(1, ins(K_PSI, 12'h220)); put(2, ins(K_PSI, 12'h055));
    put(3, ins(K_ST, 0)); put(4, ins(K_PSM, 12'h220)); put(5, ins(K_OP, 0));
    put(6, ins(K_OUT, 0)); put(7, ins(K_HALT, 0));
    run_prog(n);
    check("R6 store then pops both", out_data, 16'h005C);
  endtask

  task automatic t_cond(input logic [3:0] jop, input int v, input logic [15:0] exp, input string req);
    int n;
    begin_prog;
    put(0, ins(K_PSI, v)); put(1, ins(jop, 5)); put(2, ins(K_PSI, 12'h011));
    put(3, ins(K_OUT, 0)); put(4, ins(K_HALT, 0));
    put(5, ins(K_PSI, 12'h022)); put(6, ins(K_OUT, 0)); put(7, ins(K_HALT, 0));
    run_prog(n);
    check(req, out_data, exp);
    check("R3 cycles across branch", 16'(n), 16'd5);
  endtask

  task automatic t_jumps;
    int n;
    begin_prog;
    put(0, ins(K_JMP, 3)); put(1, ins(K_PSI, 1)); put(2, ins(K_OUT, 0));
    put(3, ins(K_PSI, 12'h077)); put(4, ins(K_OUT, 0)); put(5, ins(K_HALT, 0));
    run_prog(n);
    check("R7 jmp", out_data, 16'h0077);
    check("R7 jmp cycles", 16'(n), 16'd4);
    begin_prog;
    put(0, ins(K_PSI, 12'h031)); put(1, ins(K_PSI, 0)); put(2, ins(K_JZ, 3));
    put(3, ins(K_OUT, 0)); put(4, ins(K_HALT, 0));
    run_prog(n);
    check("R7 jz pops", out_data, 16'h0031);
    // countdown loop: 5 passes adding 3 into word 0x301
    begin_prog;
    put(0, ins(K_PSI, 5)); put(1, ins(K_POP, 12'h300));
    put(2, ins(K_PSM, 12'h301)); put(3, ins(K_PSI, 3)); put(4, ins(K_OP, 0)); put(5, ins(K_POP, 12'h301));
    put(6, ins(K_PSM, 12'h300)); put(7, ins(K_PSI, 1)); put(8, ins(K_OP, 1)); put(9, ins(K_POP, 12'h300));
    put(10, ins(K_PSM, 12'h300)); put(11, ins(K_JNZ, 2));
    put(12, ins(K_PSM, 12'h301)); put(13, ins(K_OUT, 0)); put(14, ins(K_HALT, 0));
    run_prog(n);
    check("R7 jnz loop result", out_data, 16'd15);
    check("R3 loop cycles", 16'(n), 16'd55);
  endtask

  task automatic t_input;
    int n;
    begin_prog;
    in_data = 16'hBEEF;
    put(0, ins(K_IN, 0)); put(1, ins(K_PSI, 1)); put(2, ins(K_OP, 0));
    put(3, ins(K_OUT, 0)); put(4, ins(K_HALT, 0));
    run_prog(n);
    check("R4 input push", out_data, 16'hBEF0);
  endtask

  task automatic t_halt_and_hold;
    int n;
    begin_prog;
    put(0, ins(K_PSI, 5)); put(1, ins(K_OUT, 0)); put(2, ins(K_PSI, 6));
    put(3, ins(K_PSI, 8)); put(4, ins(K_OP, 0)); put(5, ins(K_IN, 0));
    put(6, ins(K_HALT, 0)); put(7, ins(K_OUT, 0)); put(8, ins(K_PSI, 2)); put(9, ins(K_OUT, 0));
    run_prog(n);
    check("R12 out held while stack changes", out_data, 16'h0005);
    for (int i = 0; i < 8; i++) begin
      in_data = 16'(16'h1111 * i);
      @(negedge clk);
    end
    check("R11 out frozen after halt", out_data, 16'h0005);
    check("R11 halted sticky", {15'h0, halted}, 16'h1);
    begin_prog;
    run_prog(n);
    check("R2 memory of zeros halts at once", 16'(n), 16'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_pushi_zero_ext;
    t_bin(0, 12'h7FF, 0, 12'h801, 0, "R8 add");
    t_bin(1, 3, 0, 5, 0, "R8 sub order");
    t_bin(2, 12'hFFF, 0, 12'hFFF, 0, "R8 mul low half");
    t_bin(3, 1, 0, 4, 0, "R8 shl");
    t_bin(4, 5, 1, 3, 0, "R8 shr logical");
    t_bin(5, 12'hF0F, 0, 12'h0FF, 0, "R8 band");
    t_bin(6, 12'hF00, 0, 12'h00F, 0, "R8 bor");
    t_bin(7, 12'hFF0, 0, 12'h0FF, 0, "R8 bxor");
    t_bin(8, 2, 0, 0, 0, "R9 logical and false");
    t_bin(8, 2, 0, 3, 0, "R9 logical and true");
    t_bin(9, 0, 0, 0, 0, "R9 logical or");
    t_bin(10, 7, 0, 7, 0, "R9 eq");
    t_bin(11, 7, 0, 7, 0, "R9 ne");
    t_bin(12, 5, 1, 3, 0, "R9 ge signed");
    t_bin(12, 4, 0, 4, 0, "R9 ge equal");
    t_bin(13, 5, 1, 3, 0, "R9 le signed");
    t_bin(14, 3, 0, 5, 1, "R9 gt signed");
    t_bin(15, 5, 1, 3, 0, "R9 lt signed");
    t_bin(15, 5, 0, 3, 0, "R9 lt false");
    t_unary(16, 5);
    t_unary(17, 12'h0F0);
    t_unary(18, 0);
    t_unary(18, 7);
    t_push_pop;
    t_load_store;
    t_cond(K_JZ, 3, 16'h0011, "R7 jz not taken");
    t_cond(K_JZ, 0, 16'h0022, "R7 jz taken");
    t_cond(K_JNZ, 3, 16'h0022, "R7 jnz taken");
    t_cond(K_JNZ, 0, 16'h0011, "R7 jnz not taken");
    t_jumps;
    t_input;
    t_halt_and_hold;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule